// File: doc/BRIEF.md
# Dual-Mode Serial Port Controller

This block owns the configuration byte of a digital telephone serial port and turns it into port behaviour. The port works either as a framed time-division link, where the first two 8-bit timeslots of each frame carry a signalling channel (slot 0) and a control channel (slot 1), or as a plain synchronous serial link clocked by a selectable bit clock. A host writes the configuration byte and the two outgoing channel bytes over a simple register strobe. It reads the configuration back, and it reads the most recent bytes received in the two timeslots.

In framed mode the block follows an externally supplied bit strobe and frame marker. It drives the outgoing timeslots MSB first when they are enabled and releases the line (output enable low) when they are not. Receive capture of both timeslots never stops. In serial mode the framed transmit path is silent. A 3-bit rate code then chooses between passing the master clock straight through as the bit clock and dividing a 4096 kHz master clock by 32 or by 16. Two reserved codes are flagged as a sticky error.

Top module: `serial_port_ctrl`

## Requirements
- R1: The configuration register is at address 0x10. Bits 6..0 are written from `wr_data` and read back unchanged, bit 7 always reads 0, and reset clears the register to 0x00. Field positions: bit 6 mode (1 = framed, 0 = serial), bit 5 control-slot enable, bit 4 signalling-slot enable, bits 3..1 rate code, bit 0 slow signalling rate.
- R2: Writes to 0x14 set the outgoing control-channel byte and writes to 0x15 set the outgoing signalling-channel byte. Reads of 0x14 and 0x15 return the last received control and signalling bytes, which are 0x00 after reset. Any other read address returns 0x00.
- R3: A `bit_en` cycle with `frm_sync` high sets the frame position to 0. Each later `bit_en` cycle advances it by one. Position p covers bit (7 - p mod 8) of its slot, with positions 0..7 in slot 0 and positions 8..15 in slot 1. Positions 16 and above, and all positions before the first frame marker, leave `tx_oe` low. `tx_bit` is 0 whenever `tx_oe` is low.
- R4: In framed mode with bit 5 high, positions 8..15 drive the control byte MSB first. With bit 5 low, slot 1 is released.
- R5: In framed mode with bit 4 high, the signalling bits lead slot 0: only position 0 is driven (byte bit 7) when bit 0 is 1 (8 kb/s), and positions 0 and 1 are driven (byte bits 7 and 6) when bit 0 is 0 (16 kb/s). All other slot-0 positions are released, and the whole slot is released when bit 4 is low.
- R6: In framed mode, `rx_bit` is sampled on each `bit_en` edge in positions 0..15 whatever bits 5 and 4 hold. The byte (first bit as MSB) becomes readable at 0x15 (slot 0) or 0x14 (slot 1) right after the edge of its eighth bit.
- R7: In serial mode `tx_oe` stays low whatever bits 5 and 4 hold, and the received-byte registers keep their values.
- R8: In serial mode, rate codes 000, 001, 010 and 011 set `bclk_bypass` high, meaning the master clock is the bit clock, and hold `bclk` low.
- R9: In serial mode, code 100 makes `bclk` a 50% square wave with a 32-cycle period, and code 101 gives a 16-cycle period. A configuration write that changes the mode or the code restarts the wave low, so that k cycles after the write edge `bclk` equals bit 0 of (k / half-period).
- R10: In serial mode, codes 110 and 111 hold `bclk` low and `bclk_bypass` low, and set `rate_err` one cycle after the write. `rate_err` stays high until the next configuration write clears it in the cycle of that write.
- R11: In framed mode the rate code bits 2..1 are ignored, `bclk` and `bclk_bypass` are low, and `rate_err` is not set. If bit 3 is high in framed mode, `cfg_err` is high and no position drives `tx_oe`, while capture (R6) continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| bit_en | input | 1 | Framed-mode bit strobe, one master clock cycle per line bit |
| frm_sync | input | 1 | Frame marker, sampled with `bit_en` |
| rx_bit | input | 1 | Receive line |
| tx_bit | output | 1 | Transmit line data |
| tx_oe | output | 1 | Transmit line drive enable (low = released) |
| bclk | output | 1 | Divided serial bit clock |
| bclk_bypass | output | 1 | High when the master clock itself is the bit clock |
| rate_err | output | 1 | Sticky invalid-rate-code flag |
| cfg_err | output | 1 | Framed mode with bit 3 set |

## Verification
A bad frame position or validity bit appears within the same frame: `tx_oe` rises on a wrong position or carries a wrong data bit, and a received byte read back after sixteen strobes comes out rotated or lands in the wrong slot. A stale divider count or a missed restart moves the first `bclk` edge away from exactly one half-period after the configuration write, so it shows at that edge. A stuck error flag shows at the first sample after the write that should set or clear it. Randomised configuration bytes mix modes, enables and rate codes frame by frame, so that the enables, the slow-rate bit and the framed/serial selection are checked in many combinations.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int CH_BITS = 8;
    localparam logic [7:0] ADDR_CTRL = 8'h10;
    localparam logic [7:0] ADDR_CCH  = 8'h14;
    localparam logic [7:0] ADDR_DCH  = 8'h15;

    typedef struct packed {
        logic       rsvd;
        logic       tdm;
        logic       c_en;
        logic       d_en;
        logic [2:0] rate;
        logic       d_slow;
    } ctrl_t;

    typedef enum logic [2:0] {
        RK_OFF,
        RK_BYPASS,
        RK_DIV32,
        RK_DIV16,
        RK_BAD
    } rate_kind_t;

    function automatic rate_kind_t classify(ctrl_t c);
        rate_kind_t k;
        if (c.tdm) begin
            k = RK_OFF;
        end else begin
            case (c.rate)
                3'b100:         k = RK_DIV32;
                3'b101:         k = RK_DIV16;
                3'b110, 3'b111: k = RK_BAD;
                default:        k = RK_BYPASS;
            endcase
        end
        return k;
    endfunction

    function automatic logic cfg_bad(ctrl_t c);
        return c.tdm & c.rate[2];
    endfunction

    function automatic logic msb_pick(logic [7:0] b, logic [2:0] idx);
        return b[3'd7 - idx];
    endfunction

    function automatic logic [2:0] d_lead_bits(logic d_slow);
        return d_slow ? 3'd1 : 3'd2;
    endfunction

endpackage

// File: rtl/spc_ctrl_regs.sv
module spc_ctrl_regs
    import spc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  rd_addr,
    input  logic [7:0]  rx_c,
    input  logic [7:0]  rx_d,
    output ctrl_t       ctrl,
    output logic [7:0]  c_tx,
    output logic [7:0]  d_tx,
    output logic [7:0]  rd_data,
    output logic        ctrl_wr,
    output logic        cfg_chg
);

    ctrl_t      ctrl_q;
    logic [7:0] c_tx_q;
    logic [7:0] d_tx_q;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign cfg_chg = ctrl_wr && ({wr_data[6], wr_data[3:1]} != {ctrl_q.tdm, ctrl_q.rate});

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            c_tx_q <= '0;
            d_tx_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: ctrl_q <= ctrl_t'({1'b0, wr_data[6:0]});
                ADDR_CCH:  c_tx_q <= wr_data;
                ADDR_DCH:  d_tx_q <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = {1'b0, ctrl_q[6:0]};
            ADDR_CCH:  rd_data = rx_c;
            ADDR_DCH:  rd_data = rx_d;
            default:   rd_data = 8'h00;
        endcase
    end

    assign ctrl = ctrl_q;
    assign c_tx = c_tx_q;
    assign d_tx = d_tx_q;

    // R1: a configuration write lands in the low seven bits.
    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_q[6:0] == $past(wr_data[6:0])));

endmodule

// File: rtl/spc_slot_engine.sv
module spc_slot_engine
    import spc_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  ctrl_t       ctrl,
    input  logic [7:0]  c_tx,
    input  logic [7:0]  d_tx,
    input  logic        bit_en,
    input  logic        frm_sync,
    input  logic        rx_bit,
    output logic        tx_bit,
    output logic        tx_oe,
    output logic [7:0]  rx_c,
    output logic [7:0]  rx_d,
    output logic        cfg_err
);

    localparam int POS_W = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] SLOT1_LO = POS_W'(CH_BITS);
    localparam logic [POS_W-1:0] SLOT_END = POS_W'(2 * CH_BITS);

    logic [POS_W-1:0] pos_q;
    logic             valid_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_c_q;
    logic [7:0]       rx_d_q;

    logic       in_ch0;
    logic       in_ch1;
    logic [2:0] bit_idx;
    logic       drive_d;
    logic       drive_c;
    logic       tdm_ok;
    logic [7:0] rx_byte;

    assign in_ch0  = valid_q && (pos_q < SLOT1_LO);
    assign in_ch1  = valid_q && (pos_q >= SLOT1_LO) && (pos_q < SLOT_END);
    assign bit_idx = pos_q[2:0];
    assign cfg_err = cfg_bad(ctrl);
    assign tdm_ok  = ctrl.tdm && !cfg_err;
    assign drive_d = tdm_ok && ctrl.d_en && in_ch0 && (bit_idx < d_lead_bits(ctrl.d_slow));
    assign drive_c = tdm_ok && ctrl.c_en && in_ch1;
    assign tx_oe   = drive_d || drive_c;
    assign rx_byte = {sh_q[6:0], rx_bit};

    always_comb begin
        if (drive_d)      tx_bit = msb_pick(d_tx, bit_idx);
        else if (drive_c) tx_bit = msb_pick(c_tx, bit_idx);
        else              tx_bit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            valid_q <= 1'b0;
        end else if (bit_en) begin
            if (frm_sync) begin
                pos_q   <= '0;
                valid_q <= 1'b1;
            end else if (pos_q != POS_LAST) begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rx_c_q <= '0;
            rx_d_q <= '0;
        end else if (bit_en && ctrl.tdm && (in_ch0 || in_ch1)) begin
            sh_q <= rx_byte;
            if (bit_idx == 3'd7) begin
                if (in_ch0) rx_d_q <= rx_byte;
                else        rx_c_q <= rx_byte;
            end
        end
    end

    assign rx_c = rx_c_q;
    assign rx_d = rx_d_q;

    // R3: the line is only driven inside the two leading slots of a started frame.
    assert_slot_window_R3: assert property (@(posedge clk) disable iff (rst)
        tx_oe |-> (valid_q && (pos_q < SLOT_END)));

    // R11: a bad framed configuration keeps the line released.
    assert_cfg_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !tx_oe);

    // R7: serial mode never drives the framed line.
    assert_serial_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.tdm |-> !tx_oe);

    // R7: received bytes hold while in serial mode.
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.tdm |=> ($stable(rx_c_q) && $stable(rx_d_q)));

endmodule

// File: rtl/spc_bclk_gen.sv
module spc_bclk_gen
    import spc_pkg::*;
#(
    parameter int DIV_SLOW = 32,
    parameter int DIV_FAST = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  ctrl_wr,
    input  logic  cfg_chg,
    output logic  bclk,
    output logic  bclk_bypass,
    output logic  rate_err
);

    localparam int CNT_W = $clog2(DIV_SLOW / 2) + 1;
    localparam logic [CNT_W-1:0] HALF_SLOW_M1 = CNT_W'(DIV_SLOW / 2 - 1);
    localparam logic [CNT_W-1:0] HALF_FAST_M1 = CNT_W'(DIV_FAST / 2 - 1);

    rate_kind_t       kind;
    logic             dividing;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt_q;
    logic             bclk_q;
    logic             err_q;

    assign kind        = classify(ctrl);
    assign dividing    = (kind == RK_DIV32) || (kind == RK_DIV16);
    assign half_m1     = (kind == RK_DIV32) ? HALF_SLOW_M1 : HALF_FAST_M1;
    assign bclk_bypass = (kind == RK_BYPASS);

    always_ff @(posedge clk) begin
        if (rst || cfg_chg || !dividing) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (cnt_q == half_m1) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) err_q <= 1'b0;
        else if (kind == RK_BAD) err_q <= 1'b1;
    end

    assign bclk     = bclk_q;
    assign rate_err = err_q;

    // R10: the error flag only rises after an invalid code was in force.
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(kind == RK_BAD));

    // R8: non-dividing selections leave the divided clock low.
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !dividing |=> !bclk_q);

    // R9: the divided clock holds its level until the half count completes.
    assert_half_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (dividing && !cfg_chg && (cnt_q != half_m1)) |=> $stable(bclk_q));

endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
    import spc_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int DIV_SLOW   = 32,
    parameter int DIV_FAST   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       bit_en,
    input  logic       frm_sync,
    input  logic       rx_bit,
    output logic       tx_bit,
    output logic       tx_oe,
    output logic       bclk,
    output logic       bclk_bypass,
    output logic       rate_err,
    output logic       cfg_err
);

    ctrl_t      ctrl;
    logic [7:0] c_tx;
    logic [7:0] d_tx;
    logic [7:0] rx_c;
    logic [7:0] rx_d;
    logic       ctrl_wr;
    logic       cfg_chg;

    spc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rx_c    (rx_c),
        .rx_d    (rx_d),
        .ctrl    (ctrl),
        .c_tx    (c_tx),
        .d_tx    (d_tx),
        .rd_data (rd_data),
        .ctrl_wr (ctrl_wr),
        .cfg_chg (cfg_chg)
    );

    spc_slot_engine #(.FRAME_BITS(FRAME_BITS)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .c_tx     (c_tx),
        .d_tx     (d_tx),
        .bit_en   (bit_en),
        .frm_sync (frm_sync),
        .rx_bit   (rx_bit),
        .tx_bit   (tx_bit),
        .tx_oe    (tx_oe),
        .rx_c     (rx_c),
        .rx_d     (rx_d),
        .cfg_err  (cfg_err)
    );

    spc_bclk_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_bclk (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .ctrl_wr     (ctrl_wr),
        .cfg_chg     (cfg_chg),
        .bclk        (bclk),
        .bclk_bypass (bclk_bypass),
        .rate_err    (rate_err)
    );

endmodule

// File: tb/serial_port_ctrl_tb_top.sv
module serial_port_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       bit_en = 1'b0;
    logic       frm_sync = 1'b0;
    logic       rx_bit = 1'b0;
    logic       tx_bit;
    logic       tx_oe;
    logic       bclk;
    logic       bclk_bypass;
    logic       rate_err;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [7:0] m_rxc = 8'h00;
    logic [7:0] m_rxd = 8'h00;

    always #4 clk = ~clk;

    serial_port_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bit_en(bit_en), .frm_sync(frm_sync),
        .rx_bit(rx_bit), .tx_bit(tx_bit), .tx_oe(tx_oe), .bclk(bclk),
        .bclk_bypass(bclk_bypass), .rate_err(rate_err), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected {oe, bit} at frame position k.
    function automatic logic [1:0] exp_tx(input logic [7:0] cr, input logic [7:0] c,
                                          input logic [7:0] d, input int k);
        int lead;
        lead = cr[0] ? 1 : 2;
        if (!cr[6] || cr[3]) return 2'b00;
        if (k < 8)  return (cr[4] && k < lead) ? {1'b1, d[7-k]} : 2'b00;
        if (k < 16) return cr[5] ? {1'b1, c[15-k]} : 2'b00;
        return 2'b00;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // One frame: sync strobe then 18 bit strobes; checks every position.
    task automatic frame(input string tag, input logic [7:0] cr, input logic [7:0] c,
                         input logic [7:0] d, input logic [7:0] rxc, input logic [7:0] rxd);
        logic [1:0] a, e;
        int bad;
        logic [1:0] ba, be;
        int bk;
        bad = 0; ba = 0; be = 0; bk = 0;
        @(negedge clk);
        frm_sync = 1'b1; bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frm_sync = 1'b0;
        for (int k = 0; k < 18; k++) begin
            a = {tx_oe, tx_bit};
            e = exp_tx(cr, c, d, k);
            if (a !== e && bad == 0) begin bad = 1; ba = a; be = e; bk = k; end
            rx_bit = (k < 8) ? rxd[7-k] : (k < 16) ? rxc[15-k] : 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        bit_en = 1'b0;
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s pos %0d {oe,bit} actual=%0b expected=%0b", tag, bk, ba, be);
        end
        if (cr[6]) begin m_rxc = rxc; m_rxd = rxd; end
    endtask

    task automatic bclk_run(input string tag, input int half, input int n);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (bclk !== 1'((k / half) % 2) && bad == 0) begin
                bad = 1;
                checks++; errors++;
                $display("FAIL %s k=%0d actual=%0b expected=%0b", tag, k, bclk, 1'((k / half) % 2));
            end
        end
        if (bad == 0) checks++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state
        rd_chk("R1 reset ctrl", 8'h10, 8'h00);
        rd_chk("R2 reset rx C", 8'h14, 8'h00);
        rd_chk("R2 reset rx D", 8'h15, 8'h00);
        chk("R7 reset tx_oe", tx_oe, 0);
        chk("R8 reset bypass", bclk_bypass, 1);
        chk("R10 reset rate_err", rate_err, 0);

        // R1 reserved bit, R11 bad framed config
        wr(8'h14, 8'hA5);
        wr(8'h15, 8'hC3);
        wr(8'h10, 8'hFF);
        rd_chk("R1 bit7 reads zero", 8'h10, 8'h7F);
        rd_chk("R2 other address", 8'h33, 8'h00);
        chk("R11 cfg_err", cfg_err, 1);
        chk("R11 framed bypass low", bclk_bypass, 0);
        frame("R11 no drive", 8'hFF, 8'hA5, 8'hC3, 8'h5A, 8'h3C);
        rd_chk("R6 capture under cfg_err C", 8'h14, m_rxc);
        rd_chk("R6 capture under cfg_err D", 8'h15, m_rxd);

        // R4/R5 enables and signalling rate
        wr(8'h10, 8'h70);
        chk("R11 cfg_err clear", cfg_err, 0);
        frame("R4 R5 both enabled 16k", 8'h70, 8'hA5, 8'hC3, 8'h81, 8'h7E);
        wr(8'h10, 8'h71);
        frame("R5 slow rate", 8'h71, 8'hA5, 8'hC3, 8'hF0, 8'h0F);
        wr(8'h10, 8'h60);
        frame("R4 C only", 8'h60, 8'hA5, 8'hC3, 8'h11, 8'h22);
        wr(8'h10, 8'h50);
        frame("R5 D only", 8'h50, 8'hA5, 8'hC3, 8'h33, 8'h44);
        wr(8'h10, 8'h40);
        frame("R6 capture with both disabled", 8'h40, 8'hA5, 8'hC3, 8'h96, 8'h69);
        rd_chk("R6 rx C", 8'h14, 8'h96);
        rd_chk("R6 rx D", 8'h15, 8'h69);

        // R11 rate bits ignored in framed mode
        wr(8'h10, 8'h46);
        chk("R11 csl ignored bypass", bclk_bypass, 0);
        chk("R11 csl ignored bclk", bclk, 0);
        chk("R11 csl ignored cfg_err", cfg_err, 0);
        chk("R11 no rate_err", rate_err, 0);

        // R7 serial mode ignores enables
        wr(8'h10, 8'h30);
        frame("R7 serial silent", 8'h30, 8'hA5, 8'hC3, 8'hEE, 8'hDD);
        rd_chk("R7 rx C kept", 8'h14, 8'h96);
        rd_chk("R7 rx D kept", 8'h15, 8'h69);

        // R8 pass-through codes
        wr(8'h10, 8'h02);
        chk("R8 code 001 bypass", bclk_bypass, 1);
        wr(8'h10, 8'h06);
        chk("R8 code 011 bypass", bclk_bypass, 1);
        chk("R8 code 011 bclk low", bclk, 0);

        // R9 dividers
        wr(8'h10, 8'h08);
        chk("R9 div32 bypass low", bclk_bypass, 0);
        bclk_run("R9 div32", 16, 80);
        wr(8'h10, 8'h0A);
        bclk_run("R9 div16 restart", 8, 40);

        // R10 invalid codes
        wr(8'h10, 8'h0C);
        chk("R10 flag clear at write", rate_err, 0);
        @(negedge clk);
        chk("R10 flag set", rate_err, 1);
        repeat (5) @(negedge clk);
        chk("R10 flag sticky", rate_err, 1);
        chk("R10 bclk low", bclk, 0);
        chk("R10 bypass low", bclk_bypass, 0);
        wr(8'h10, 8'h0E);
        chk("R10 cleared by write", rate_err, 0);
        @(negedge clk);
        chk("R10 code 111 sets", rate_err, 1);
        wr(8'h10, 8'h00);
        repeat (3) @(negedge clk);
        chk("R10 stays clear", rate_err, 0);

        // Random frames
        for (int i = 0; i < 40; i++) begin
            logic [7:0] cr, c, d, rc, rdd;
            cr = 8'($urandom); c = 8'($urandom); d = 8'($urandom);
            rc = 8'($urandom); rdd = 8'($urandom);
            wr(8'h14, c);
            wr(8'h15, d);
            wr(8'h10, cr);
            rd_chk("R1 random readback", 8'h10, {1'b0, cr[6:0]});
            chk("R11 random cfg_err", cfg_err, 32'(cr[6] & cr[3]));
            frame("R3 random frame", cr, c, d, rc, rdd);
            rd_chk("R6 random rx C", 8'h14, m_rxc);
            rd_chk("R6 random rx D", 8'h15, m_rxd);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule